// File: doc/BRIEF.md
# Display Self-Test Sequencer

This block carries out the built-in test of a dot-matrix character display controller. A one-cycle start strobe, raised when the host writes the control word with its test bit (bit 6) set, launches a fixed-length sequence of exactly 2^(VIS_LOG2+2) clocks. That is 262,144 clocks at the default setting. The sequence has four parts:

- A checksum pass reads every address of the glyph table through a read port with one cycle of latency. It adds up the returned 5-bit dot rows into an 8-bit sum that wraps, and compares that sum with the parameter `EXPECT_SUM`. The outcome is latched as a result bit, which the register file returns as read-only control-word bit 5 (1 = pass).
- An idle tail fills the first half of the sequence.
- A visual pass then overrides the display's column data with a checkerboard for 2^VIS_LOG2 clocks.
- The inverse checkerboard follows for another 2^VIS_LOG2 clocks.

In the last busy cycle the block raises a one-cycle done strobe. The register file uses this strobe to load the end-of-test state:

- every character cell set to blank (20h)
- the control word cleared except bit 5, which takes the result
- all flash bits cleared
- the user-glyph address register set to all ones

The host must stay off the bus while busy is high.

The state machine has seven states. IDLE waits for a start. WALK presents glyph addresses. DRAIN absorbs the last read. JUDGE compares the sum. TAIL waits out the first half. CHECKER shows the pattern and INVERSE shows its complement. The transitions are:

- IDLE→WALK on start.
- WALK→DRAIN after the last address.
- DRAIN→JUDGE and JUDGE→TAIL unconditionally.
- TAIL→CHECKER at the half-way count.
- CHECKER→INVERSE after 2^VIS_LOG2 pattern clocks.
- INVERSE→IDLE in the final cycle, together with the done strobe.

Top module: `selftest_sequencer`

## Requirements
- R1: After reset, busy, done, pattern enable, pattern invert, all column outputs and the result bit are 0.
- R2: A start strobe sampled while idle makes busy 1 from the next cycle, for exactly 2^(VIS_LOG2+2) consecutive cycles. Counting those busy cycles from index 0, busy is 0 at index 2^(VIS_LOG2+2).
- R3: A start strobe sampled while busy, including in the final busy cycle, is ignored: the phase timing and the end of busy are unchanged.
- R4: In busy cycles 0 to 2^ROM_AW-1, the glyph address equals the busy-cycle index. The glyph data for an address is expected one cycle after that address is presented.
- R5: The result bit becomes 1 if the 8-bit wrapping sum of all 2^ROM_AW returned rows equals `EXPECT_SUM`, and 0 otherwise. It keeps its old value through busy index 2^ROM_AW+1 and shows the new value from index 2^ROM_AW+2. It never changes while idle.
- R6: In busy indices 2^(VIS_LOG2+1) to 2^(VIS_LOG2+1)+2^VIS_LOG2-1, pattern enable is 1 and invert is 0. Columns (bit 4..0) show 10101 for an even row (row-odd input 0) and 01010 for an odd row.
- R7: In the next 2^VIS_LOG2 busy indices, pattern enable and invert are both 1 and the columns are the bitwise complement of the R6 pattern.
- R8: Outside the two visual phases, pattern enable and invert are 0 and the column outputs are all 0.
- R9: Done is 1 for exactly one cycle, the last busy cycle (index 2^(VIS_LOG2+2)-1), and busy is 0 in the cycle after it. Done is the request for the end-of-test register state.
- R10: A second test reports its own outcome: a previous pass is replaced by fail when the sum mismatches. An active-low reset during a test returns to the R1 state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe from a control-word write with the test bit set |
| rom_addr_o | output | ROM_AW | Glyph table address |
| rom_data_i | input | ROM_DW | Glyph row data, valid one cycle after the address |
| pat_row_odd_i | input | 1 | 1 while the display scans an odd dot row |
| busy_o | output | 1 | Test in progress; host access forbidden |
| pat_en_o | output | 1 | Pattern overrides the display columns |
| pat_inv_o | output | 1 | Inverse checkerboard selected |
| pat_cols_o | output | COLS | Override column dots for the current row |
| result_o | output | 1 | Latched checksum outcome, 1 = pass |
| done_o | output | 1 | One-cycle end-of-test strobe and load request |

## Verification
The start decoder and the end-of-sequence logic can act in the same cycle: a stray start strobe can arrive in the very cycle that done is high. The bench drives start in that final busy cycle, and also once in mid-test. It judges the design correct only if busy is low at the next sample and no new walk begins. A similar overlap occurs between the last glyph read and the compare: the bench checks that the result keeps its old value one cycle after the drain and changes in the following cycle.

// File: rtl/selftest_pkg.sv
package selftest_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WALK,
        ST_DRAIN,
        ST_JUDGE,
        ST_TAIL,
        ST_CHECKER,
        ST_INVERSE
    } st_state_e;
endpackage

// File: rtl/selftest_cycle_counter.sv
module selftest_cycle_counter #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    output logic [W-1:0] cnt_o
);
    timeunit 1ns;
    timeprecision 1ps;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_o <= '0;
        else if (clr_i)  cnt_o <= '0;
        else if (en_i)   cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/selftest_checksum.sv
module selftest_checksum #(
    parameter int ROM_AW = 7,
    parameter int ROM_DW = 5,
    parameter int SUM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              walk_i,
    input  logic [ROM_AW-1:0] idx_i,
    output logic [ROM_AW-1:0] rom_addr_o,
    input  logic [ROM_DW-1:0] rom_data_i,
    output logic [SUM_W-1:0]  sum_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PAD = SUM_W - ROM_DW;

    logic valid_q;

    // address goes out while walking; data follows one cycle later
    assign rom_addr_o = walk_i ? idx_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            sum_o   <= '0;
        end else if (clr_i) begin
            valid_q <= 1'b0;
            sum_o   <= '0;
        end else begin
            valid_q <= walk_i;
            if (valid_q) sum_o <= sum_o + {{PAD{1'b0}}, rom_data_i};
        end
    end
endmodule

// File: rtl/selftest_pattern_gen.sv
module selftest_pattern_gen #(
    parameter int COLS = 5
) (
    input  logic            en_i,
    input  logic            inv_i,
    input  logic            row_odd_i,
    output logic [COLS-1:0] cols_o
);
    timeunit 1ns;
    timeprecision 1ps;

    // even column lit on even row; every row/inversion flips parity
    for (genvar c = 0; c < COLS; c++) begin : g_col
        localparam logic COL_ODD = ((c % 2) == 1);
        assign cols_o[c] = en_i & ~(COL_ODD ^ row_odd_i ^ inv_i);
    end
endmodule

// File: rtl/selftest_sequencer.sv
module selftest_sequencer
    import selftest_pkg::*;
#(
    parameter int               ROM_AW     = 7,
    parameter int               ROM_DW     = 5,
    parameter int               COLS       = 5,
    parameter int               VIS_LOG2   = 16,
    parameter int               SUM_W      = 8,
    parameter logic [SUM_W-1:0] EXPECT_SUM = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic [ROM_AW-1:0] rom_addr_o,
    input  logic [ROM_DW-1:0] rom_data_i,
    input  logic              pat_row_odd_i,
    output logic              busy_o,
    output logic              pat_en_o,
    output logic              pat_inv_o,
    output logic [COLS-1:0]   pat_cols_o,
    output logic              result_o,
    output logic              done_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int             CNT_W     = VIS_LOG2 + 2;
    localparam logic [CNT_W-1:0] WALK_LAST = CNT_W'(2**ROM_AW - 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(2**(VIS_LOG2+1) - 1);
    localparam logic [CNT_W-1:0] CHK_LAST  = CNT_W'(2**(VIS_LOG2+1) + 2**VIS_LOG2 - 1);
    localparam logic [CNT_W-1:0] END_LAST  = '1;

    st_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt;
    logic [SUM_W-1:0]  sum;
    logic              start_ok;
    logic              result_q;

    assign start_ok = (state_q == ST_IDLE) && start_i;
    assign result_o = result_q;

    selftest_cycle_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (start_ok),
        .en_i  (state_q != ST_IDLE),
        .cnt_o (cnt)
    );

    selftest_checksum #(.ROM_AW(ROM_AW), .ROM_DW(ROM_DW), .SUM_W(SUM_W)) u_sum (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (start_ok),
        .walk_i     (state_q == ST_WALK),
        .idx_i      (cnt[ROM_AW-1:0]),
        .rom_addr_o (rom_addr_o),
        .rom_data_i (rom_data_i),
        .sum_o      (sum)
    );

    selftest_pattern_gen #(.COLS(COLS)) u_pat (
        .en_i      (pat_en_o),
        .inv_i     (pat_inv_o),
        .row_odd_i (pat_row_odd_i),
        .cols_o    (pat_cols_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i)             state_d = ST_WALK;
            ST_WALK:    if (cnt == WALK_LAST)    state_d = ST_DRAIN;
            ST_DRAIN:                            state_d = ST_JUDGE;
            ST_JUDGE:                            state_d = ST_TAIL;
            ST_TAIL:    if (cnt == HALF_LAST)    state_d = ST_CHECKER;
            ST_CHECKER: if (cnt == CHK_LAST)     state_d = ST_INVERSE;
            ST_INVERSE: if (cnt == END_LAST)     state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o    = 1'b1;
        pat_en_o  = 1'b0;
        pat_inv_o = 1'b0;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:    busy_o = 1'b0;
            ST_WALK, ST_DRAIN, ST_JUDGE, ST_TAIL: ;
            ST_CHECKER: pat_en_o = 1'b1;
            ST_INVERSE: begin
                pat_en_o  = 1'b1;
                pat_inv_o = 1'b1;
                done_o    = (cnt == END_LAST);
            end
            default:    busy_o = 1'b0;
        endcase
    end

    // verdict latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   result_q <= 1'b0;
        else if (state_q == ST_JUDGE) result_q <= (sum == EXPECT_SUM);
    end
endmodule

// File: rtl/selftest_sequencer_chk.sv
module selftest_sequencer_chk #(
    parameter int ROM_AW   = 7,
    parameter int COLS     = 5,
    parameter int VIS_LOG2 = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ROM_AW-1:0] rom_addr_o,
    input logic              pat_row_odd_i,
    input logic              busy_o,
    input logic              pat_en_o,
    input logic              pat_inv_o,
    input logic [COLS-1:0]   pat_cols_o,
    input logic              result_o,
    input logic              done_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int RW = VIS_LOG2 + 3;
    localparam logic [RW-1:0] LAST_IDX = RW'(2**(VIS_LOG2+2) - 1);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= '0;
        else if (busy_o) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    p_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_q == LAST_IDX));

    p_hold_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    p_walk_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_addr_o != '0) |-> (rom_addr_o == ROM_AW'($past(rom_addr_o) + 1'b1)));

    p_result_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(result_o));

    p_inv_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pat_inv_o) |-> ($past(pat_en_o) && pat_en_o));

    p_even_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_en_o && !pat_inv_o && !pat_row_odd_i) |-> pat_cols_o[0]);

    p_pat_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pat_en_o |-> busy_o);

    p_cols_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pat_en_o |-> (pat_cols_o == '0));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
endmodule

bind selftest_sequencer selftest_sequencer_chk #(
    .ROM_AW   (ROM_AW),
    .COLS     (COLS),
    .VIS_LOG2 (VIS_LOG2)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .rom_addr_o    (rom_addr_o),
    .pat_row_odd_i (pat_row_odd_i),
    .busy_o        (busy_o),
    .pat_en_o      (pat_en_o),
    .pat_inv_o     (pat_inv_o),
    .pat_cols_o    (pat_cols_o),
    .result_o      (result_o),
    .done_o        (done_o)
);

// File: tb/selftest_sequencer_bench.sv
module selftest_sequencer_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW    = 7;
    localparam int DW    = 5;
    localparam int VIS   = 7;
    localparam int TOTAL = 2**(VIS+2);
    localparam int WALK  = 2**AW;

    function automatic logic [DW-1:0] glyph(input int a);
        return DW'((a * 13 + 5) % 32);
    endfunction

    function automatic logic [7:0] good_sum();
        logic [7:0] s = '0;
        for (int a = 0; a < WALK; a++) s = s + 8'(glyph(a));
        return s;
    endfunction

    localparam logic [7:0] GOOD = good_sum();

    typedef struct packed {
        logic [15:0] idx;
        logic        busy;
        logic        pat;
        logic        inv;
        logic        done;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{16'd0,   1'b1, 1'b0, 1'b0, 1'b0},
        '{16'd128, 1'b1, 1'b0, 1'b0, 1'b0},
        '{16'd129, 1'b1, 1'b0, 1'b0, 1'b0},
        '{16'd255, 1'b1, 1'b0, 1'b0, 1'b0},
        '{16'd256, 1'b1, 1'b1, 1'b0, 1'b0},
        '{16'd383, 1'b1, 1'b1, 1'b0, 1'b0},
        '{16'd384, 1'b1, 1'b1, 1'b1, 1'b0},
        '{16'd510, 1'b1, 1'b1, 1'b1, 1'b0},
        '{16'd511, 1'b1, 1'b1, 1'b1, 1'b1},
        '{16'd512, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          row_odd = 1'b0;
    logic          corrupt = 1'b0;
    logic [AW-1:0] rom_addr;
    logic [DW-1:0] rom_data = '0;
    logic          busy, pat_en, pat_inv, result, done;
    logic [4:0]    cols;
    int            n_chk = 0;
    int            n_bad = 0;

    always #4 clk = ~clk;

    always_ff @(posedge clk)
        rom_data <= glyph(int'(rom_addr)) ^ ((corrupt && rom_addr == AW'(9)) ? DW'(1) : DW'(0));

    selftest_sequencer #(
        .ROM_AW(AW), .ROM_DW(DW), .COLS(5), .VIS_LOG2(VIS), .SUM_W(8), .EXPECT_SUM(GOOD)
    ) u_selftest_sequencer (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .rom_addr_o(rom_addr), .rom_data_i(rom_data), .pat_row_odd_i(row_odd),
        .busy_o(busy), .pat_en_o(pat_en), .pat_inv_o(pat_inv), .pat_cols_o(cols),
        .result_o(result), .done_o(done)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_cols(input logic p, input logic inv, input logic odd);
        if (!p) return 0;
        return ((odd ? 5'h0A : 5'h15) ^ (inv ? 5'h1F : 5'h00));
    endfunction

    task automatic check_idle(input string tag);
        check({tag, " busy"}, busy, 0);
        check({tag, " done"}, done, 0);
        check({tag, " pat_en"}, pat_en, 0);
        check({tag, " pat_inv"}, pat_inv, 0);
        check({tag, " cols"}, cols, 0);
        check({tag, " result"}, result, 0);
    endtask

    // one full test; poke sends stray starts mid-run and in the done cycle (R3)
    task automatic run_test(input logic bad, input logic old_res, input logic new_res,
                            input logic poke);
        logic walk_ok = 1'b1;
        corrupt = bad;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k <= TOTAL; k++) begin
            if (k > 0) @(negedge clk);
            row_odd = k[0];
            start = poke && (k == 200 || k == TOTAL - 1);
            #1;
            if (k < WALK && rom_addr != AW'(k)) walk_ok = 1'b0;
            for (int v = 0; v < NV; v++) begin
                if (int'(VECS[v].idx) == k) begin
                    check($sformatf("R2 R3 busy @%0d", k), busy, VECS[v].busy);
                    check($sformatf("R6 R7 R8 pat_en @%0d", k), pat_en, VECS[v].pat);
                    check($sformatf("R7 pat_inv @%0d", k), pat_inv, VECS[v].inv);
                    check($sformatf("R9 done @%0d", k), done, VECS[v].done);
                    check($sformatf("R6 R7 R8 cols @%0d", k), cols,
                          exp_cols(VECS[v].pat, VECS[v].inv, row_odd));
                end
            end
            if (k == WALK + 1) check("R5 result held before judge", result, old_res);
            if (k == WALK + 2) check("R5 R10 result after judge", result, new_res);
        end
        start = 1'b0;
        check("R4 address walk", walk_ok, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R2: got busy=%0d expected run to end", busy);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 check_idle("R1 reset");
        rst_n = 1'b1;
        @(negedge clk); #1 check_idle("R1 after release");

        run_test(1'b0, 1'b0, 1'b1, 1'b1);   // pass, with ignored starts
        run_test(1'b1, 1'b1, 1'b0, 1'b0);   // R10: pass replaced by fail
        run_test(1'b0, 1'b0, 1'b1, 1'b0);   // pass again

        // R10: reset in the middle of a test
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (300) @(negedge clk);
        #1 check("R10 busy mid-test", busy, 1);
        rst_n = 1'b0;
        #1 check_idle("R10 R1 reset mid-test");
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1 check("R10 stays idle", busy, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule